// File: doc/BRIEF.md
# Peripheral Clock-Stop and Reset Control Bank

This block keeps one reset bit and one clock-stop bit for each of up to 64 peripherals and drives a registered reset line and a registered clock-enable line for each of them. The bits are packed into 32-bit control words. There are two reset words and two clock-stop words. Software reaches them through a single-cycle register port.

Every word has two addresses. A write to the first address sets the bits written as one. A write to the second address, four bytes higher, clears the bits written as one. Bits written as zero keep their value, so software can change any group of peripherals without a read-modify-write and without a lock. A read of either address returns the current word.

Peripheral index i lives in word i/32 at bit position i%32. A reset bit at one holds its peripheral in reset. A clock-stop bit at one stops the clock, except at positions set in a per-bit polarity mask (by default only index 14), where one lets the clock run. A typical enable sequence is: set the reset bit, start the clock, wait, then clear the reset bit.

Top module: `periph_ctl_bank`

## Requirements
- R1: After reset, both reset words read 0xFFFFFFFF, clock word 0 reads 0xFFFFBFFF and clock word 1 reads 0xFFFFFFFF. `periph_rst` is all ones and `clk_en` is all zeros.
- R2: A write to a word's set address (reset words at 0x040 and 0x050, clock words at 0x080 and 0x090) sets every bit written as 1. Bits written as 0 are unchanged.
- R3: A write to a word's clear address (set address + 0x4) clears every bit written as 1. Bits written as 0 are unchanged.
- R4: A read of either the set address or the clear address returns the current word on `rsp_rdata` at the clock edge that samples the read request.
- R5: Peripheral index i maps to word i/32 (index 0 to 31 at 0x040/0x080, index 32 to 63 at 0x050/0x090) and to bit i%32.
- R6: `periph_rst[i]` equals reset bit i, one clock edge after the bit changes.
- R7: `clk_en[i]` is the inverse of clock-stop bit i, except at index 14, where `clk_en[14]` equals the bit. The output follows one clock edge after the bit changes.
- R8: A read of any offset other than the eight decoded ones returns zero, and a write to such an offset changes no bit.
- R9: An access with `req_valid` low changes no bit, whatever the other request inputs hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register access request in this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 12 | Byte offset of the access |
| req_wdata | input | 32 | Write data (bit mask for set or clear) |
| rsp_rdata | output | 32 | Read data, registered on the request edge |
| periph_rst | output | 64 | Per-peripheral reset, active high |
| clk_en | output | 64 | Per-peripheral clock enable, active high |

## Verification
The assertions assume that `req_write`, `req_addr` and `req_wdata` are known whenever `req_valid` is high. They also assume that the address map parameters place the eight decoded offsets at distinct addresses. The bench keeps within these limits: it drives every request input on the falling edge from a known value, holds all inputs at zero from time zero through reset, and uses only the default map. It first walks a single cleared bit through every position of all four words. It then applies pseudo-random masks to both aliases. Finally it sweeps every 12-bit offset outside the map, so the undecoded-address rule is exercised at every address the port can present.

// File: rtl/periph_ctl_pkg.sv
`timescale 1ns/1ps
package periph_ctl_pkg;

   localparam int unsigned CTL_WORD_W     = 32;
   localparam int unsigned RST_BANK_BASE  = 'h040;
   localparam int unsigned CLK_BANK_BASE  = 'h080;
   localparam int unsigned BANK_STRIDE    = 'h010;
   localparam int unsigned CLR_ALIAS_OFS  = 'h004;
   localparam int unsigned NUM_BANKS      = 2;

   // bank 0 holds the reset words, bank 1 the clock-stop words
   function automatic int unsigned set_offset(input int unsigned bank_base,
                                              input int unsigned word_idx,
                                              input int unsigned stride);
      return bank_base + word_idx * stride;
   endfunction

   function automatic int unsigned words_needed(input int unsigned n_bits,
                                                input int unsigned word_w);
      return (n_bits + word_w - 1) / word_w;
   endfunction

endpackage

// File: rtl/periph_ctl_decode.sv
`timescale 1ns/1ps
module periph_ctl_decode
   import periph_ctl_pkg::*;
#(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned NUM_WORDS = 2,
   parameter int unsigned RST_BASE  = RST_BANK_BASE,
   parameter int unsigned CLK_BASE  = CLK_BANK_BASE,
   parameter int unsigned STRIDE    = BANK_STRIDE,
   parameter int unsigned CLR_OFS   = CLR_ALIAS_OFS
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    addr,
   output logic [NUM_WORDS-1:0] rst_set_sel,
   output logic [NUM_WORDS-1:0] rst_clr_sel,
   output logic [NUM_WORDS-1:0] clk_set_sel,
   output logic [NUM_WORDS-1:0] clk_clr_sel,
   output logic                 any_hit
);

   localparam int unsigned RST_TOP  = set_offset(RST_BASE, NUM_WORDS, STRIDE);
   localparam int unsigned CLK_TOP  = set_offset(CLK_BASE, NUM_WORDS, STRIDE);
   localparam int unsigned ADDR_LIM = 1 << ADDR_W;

   // elaboration-time map checks
   if (CLR_OFS == 0 || CLR_OFS >= STRIDE) begin : g_bad_alias
      $error("clear alias offset must lie inside one word stride");
   end
   if (RST_BASE < CLK_TOP && CLK_BASE < RST_TOP) begin : g_bad_overlap
      $error("reset and clock banks overlap");
   end
   if (RST_TOP > ADDR_LIM || CLK_TOP > ADDR_LIM) begin : g_bad_width
      $error("address map exceeds the address width");
   end

   logic [NUM_BANKS-1:0][NUM_WORDS-1:0] set_hit;
   logic [NUM_BANKS-1:0][NUM_WORDS-1:0] clr_hit;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam int unsigned BASE = (b == 0) ? RST_BASE : CLK_BASE;
      for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
         localparam int unsigned SET_A = set_offset(BASE, w, STRIDE);
         localparam int unsigned CLR_A = SET_A + CLR_OFS;
         assign set_hit[b][w] = (addr == ADDR_W'(SET_A));
         assign clr_hit[b][w] = (addr == ADDR_W'(CLR_A));
      end
   end

   assign rst_set_sel = set_hit[0];
   assign rst_clr_sel = clr_hit[0];
   assign clk_set_sel = set_hit[1];
   assign clk_clr_sel = clr_hit[1];
   assign any_hit     = |{set_hit, clr_hit};

   // R8: an address selects at most one target, so no write reaches two words
   a_r8_single_target: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({set_hit, clr_hit}));

endmodule

// File: rtl/periph_ctl_word.sv
`timescale 1ns/1ps
module periph_ctl_word #(
   parameter int unsigned W       = 32,
   parameter logic [W-1:0] RST_VAL = '1
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_en,
   input  logic         clr_en,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= RST_VAL;
      end else if (set_en) begin
         q <= q | wdata;
      end else if (clr_en) begin
         q <= q & ~wdata;
      end
   end

   // R2: every bit written as one through the set alias reads one afterwards
   a_r2_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
      set_en |=> ((q & $past(wdata)) == $past(wdata)));

   // R3: every bit written as one through the clear alias reads zero afterwards
   a_r3_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && !set_en) |=> ((q & $past(wdata)) == '0));

   // R2 / R3: bits written as zero keep their value
   a_r2_zero_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (set_en || clr_en) |=> ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata))));

   // R9: without an enable the word holds
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_en && !clr_en) |=> $stable(q));

endmodule

// File: rtl/periph_ctl_outs.sv
`timescale 1ns/1ps
module periph_ctl_outs #(
   parameter int unsigned  N             = 64,
   parameter logic [N-1:0] RUN_HIGH_MASK = N'(64'h4000)
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] rst_bits,
   input  logic [N-1:0] stop_bits,
   output logic [N-1:0] periph_rst,
   output logic [N-1:0] clk_en
);

   logic [N-1:0] en_d;

   // per-bit polarity chosen at elaboration
   for (genvar i = 0; i < N; i++) begin : g_bit
      if (RUN_HIGH_MASK[i]) begin : g_run_high
         assign en_d[i] = stop_bits[i];
      end else begin : g_stop_high
         assign en_d[i] = ~stop_bits[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         periph_rst <= '1;
         clk_en     <= '0;
      end else begin
         periph_rst <= rst_bits;
         clk_en     <= en_d;
      end
   end

   // R6: a reset line drops only after its control bit was cleared
   a_r6_release_follows_bit: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(periph_rst[0]) |-> !$past(rst_bits[0]));

endmodule

// File: rtl/periph_ctl_bank.sv
`timescale 1ns/1ps
module periph_ctl_bank
   import periph_ctl_pkg::*;
#(
   parameter int unsigned  NUM_PERIPH    = 64,
   parameter int unsigned  WORD_W        = CTL_WORD_W,
   parameter int unsigned  ADDR_W        = 12,
   parameter int unsigned  RST_BASE      = RST_BANK_BASE,
   parameter int unsigned  CLK_BASE      = CLK_BANK_BASE,
   parameter int unsigned  STRIDE        = BANK_STRIDE,
   parameter int unsigned  CLR_OFS       = CLR_ALIAS_OFS,
   parameter logic [NUM_PERIPH-1:0] RUN_HIGH_MASK = NUM_PERIPH'(64'h4000),
   parameter bit           REG_RDATA     = 1'b1
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  logic                  req_write,
   input  logic [ADDR_W-1:0]     req_addr,
   input  logic [WORD_W-1:0]     req_wdata,
   output logic [WORD_W-1:0]     rsp_rdata,
   output logic [NUM_PERIPH-1:0] periph_rst,
   output logic [NUM_PERIPH-1:0] clk_en
);

   localparam int unsigned NUM_WORDS = words_needed(NUM_PERIPH, WORD_W);
   localparam int unsigned TOT_BITS  = NUM_WORDS * WORD_W;
   localparam logic [TOT_BITS-1:0] RUN_MASK_EXT = TOT_BITS'(RUN_HIGH_MASK);

   if (NUM_PERIPH == 0) begin : g_bad_count
      $error("at least one peripheral is required");
   end
   if (WORD_W == 0 || WORD_W > 32) begin : g_bad_word
      $error("word width must be between 1 and 32");
   end

   logic wr_en;
   logic rd_en;
   assign wr_en = req_valid &  req_write;
   assign rd_en = req_valid & ~req_write;

   logic [NUM_WORDS-1:0] rst_set_sel, rst_clr_sel, clk_set_sel, clk_clr_sel;
   logic                 any_hit;

   periph_ctl_decode #(
      .ADDR_W    (ADDR_W),
      .NUM_WORDS (NUM_WORDS),
      .RST_BASE  (RST_BASE),
      .CLK_BASE  (CLK_BASE),
      .STRIDE    (STRIDE),
      .CLR_OFS   (CLR_OFS)
   ) u_decode (
      .clk         (clk),
      .rst_n       (rst_n),
      .addr        (req_addr),
      .rst_set_sel (rst_set_sel),
      .rst_clr_sel (rst_clr_sel),
      .clk_set_sel (clk_set_sel),
      .clk_clr_sel (clk_clr_sel),
      .any_hit     (any_hit)
   );

   logic [TOT_BITS-1:0] rst_state;
   logic [TOT_BITS-1:0] stop_state;

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      periph_ctl_word #(
         .W       (WORD_W),
         .RST_VAL ({WORD_W{1'b1}})
      ) u_rst_word (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_en (wr_en & rst_set_sel[w]),
         .clr_en (wr_en & rst_clr_sel[w]),
         .wdata  (req_wdata),
         .q      (rst_state[w*WORD_W +: WORD_W])
      );

      periph_ctl_word #(
         .W       (WORD_W),
         .RST_VAL (~RUN_MASK_EXT[w*WORD_W +: WORD_W])
      ) u_stop_word (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_en (wr_en & clk_set_sel[w]),
         .clr_en (wr_en & clk_clr_sel[w]),
         .wdata  (req_wdata),
         .q      (stop_state[w*WORD_W +: WORD_W])
      );
   end

   // read mux: either alias of a word returns that word
   logic [WORD_W-1:0] rd_word;
   always_comb begin
      rd_word = '0;
      for (int w = 0; w < NUM_WORDS; w++) begin
         if (rst_set_sel[w] || rst_clr_sel[w]) begin
            rd_word = rd_word | rst_state[w*WORD_W +: WORD_W];
         end
         if (clk_set_sel[w] || clk_clr_sel[w]) begin
            rd_word = rd_word | stop_state[w*WORD_W +: WORD_W];
         end
      end
   end

   if (REG_RDATA) begin : g_rd_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rsp_rdata <= '0;
         end else if (rd_en) begin
            rsp_rdata <= rd_word;
         end
      end

      // R8: a read of an undecoded offset returns zero
      a_r8_undecoded_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_en && !any_hit) |=> (rsp_rdata == '0));

      // R4: read data changes only in answer to a read
      a_r4_rdata_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
         !rd_en |=> $stable(rsp_rdata));
   end else begin : g_rd_comb
      assign rsp_rdata = rd_en ? rd_word : '0;
   end

   periph_ctl_outs #(
      .N             (NUM_PERIPH),
      .RUN_HIGH_MASK (RUN_HIGH_MASK)
   ) u_outs (
      .clk        (clk),
      .rst_n      (rst_n),
      .rst_bits   (rst_state[NUM_PERIPH-1:0]),
      .stop_bits  (stop_state[NUM_PERIPH-1:0]),
      .periph_rst (periph_rst),
      .clk_en     (clk_en)
   );

endmodule

// File: tb/periph_ctl_bank_bench.sv
`timescale 1ns/1ps
module periph_ctl_bank_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [11:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic [31:0] rsp_rdata;
   logic [63:0] periph_rst;
   logic [63:0] clk_en;

   always #2 clk = ~clk;

   periph_ctl_bank u_periph_ctl_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_write  (req_write),
      .req_addr   (req_addr),
      .req_wdata  (req_wdata),
      .rsp_rdata  (rsp_rdata),
      .periph_rst (periph_rst),
      .clk_en     (clk_en)
   );

   int checks = 0;
   int errors = 0;
   logic [31:0] m_rst [2];
   logic [31:0] m_stop [2];
   logic [31:0] lfsr = 32'h1d2c_3b4a;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [11:0] word_addr(input int bank, input int w, input bit clr);
      return 12'((bank == 0 ? 'h040 : 'h080) + 'h10 * w + (clr ? 4 : 0));
   endfunction

   function automatic bit is_decoded(input logic [11:0] a);
      for (int b = 0; b < 2; b++)
         for (int w = 0; w < 2; w++)
            if (a == word_addr(b, w, 0) || a == word_addr(b, w, 1)) return 1'b1;
      return 1'b0;
   endfunction

   task automatic model_write(input logic [11:0] a, input logic [31:0] d);
      for (int w = 0; w < 2; w++) begin
         if (a == word_addr(0, w, 0)) m_rst[w]  = m_rst[w] | d;
         if (a == word_addr(0, w, 1)) m_rst[w]  = m_rst[w] & ~d;
         if (a == word_addr(1, w, 0)) m_stop[w] = m_stop[w] | d;
         if (a == word_addr(1, w, 1)) m_stop[w] = m_stop[w] & ~d;
      end
   endtask

   task automatic bus_write(input logic [11:0] a, input logic [31:0] d, input bit valid);
      @(negedge clk);
      req_valid = valid; req_write = 1'b1; req_addr = a; req_wdata = d;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0; req_wdata = '0;
   endtask

   task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a;
      @(posedge clk);
      @(negedge clk);
      d = rsp_rdata;
      req_valid = 1'b0;
   endtask

   // outputs lag the state by one edge
   task automatic check_outs(input string tag_rst, input string tag_en);
      @(posedge clk);
      @(negedge clk);
      chk(tag_rst, periph_rst, {m_rst[1], m_rst[0]});
      chk(tag_en, clk_en, ~{m_stop[1], m_stop[0]} ^ 64'h4000);
   endtask

   task automatic check_words(input string tag);
      logic [31:0] d;
      for (int b = 0; b < 2; b++)
         for (int w = 0; w < 2; w++)
            for (int c = 0; c < 2; c++) begin
               bus_read(word_addr(b, w, c[0]), d);
               chk(tag, {32'h0, d}, {32'h0, (b == 0) ? m_rst[w] : m_stop[w]});
            end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] d;
      m_rst[0] = 32'hffff_ffff; m_rst[1] = 32'hffff_ffff;
      m_stop[0] = 32'hffff_bfff; m_stop[1] = 32'hffff_ffff;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state of outputs and words
      chk("R1 periph_rst", periph_rst, 64'hffff_ffff_ffff_ffff);
      chk("R1 clk_en", clk_en, 64'h0);
      check_words("R1 words");

      // walking single bit through every position of all four words
      for (int b = 0; b < 2; b++)
         for (int w = 0; w < 2; w++)
            for (int i = 0; i < 32; i++) begin
               bus_write(word_addr(b, w, 1), 32'h1 << i, 1'b1);
               model_write(word_addr(b, w, 1), 32'h1 << i);
               check_outs("R5 R6 periph_rst after clear", "R5 R7 clk_en after clear");
               bus_read(word_addr(b, w, 0), d);
               chk("R3 clear readback", {32'h0, d}, {32'h0, (b == 0) ? m_rst[w] : m_stop[w]});
               bus_write(word_addr(b, w, 0), 32'h1 << i, 1'b1);
               model_write(word_addr(b, w, 0), 32'h1 << i);
               bus_read(word_addr(b, w, 1), d);
               chk("R2 R4 set readback via alias", {32'h0, d}, {32'h0, (b == 0) ? m_rst[w] : m_stop[w]});
               check_outs("R6 periph_rst after set", "R7 clk_en after set");
            end

      // pseudo-random masks on both aliases
      for (int k = 0; k < 48; k++) begin
         logic [11:0] a;
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         a = word_addr(int'(lfsr[9]), int'(lfsr[5]), lfsr[13]);
         bus_write(a, lfsr, 1'b1);
         model_write(a, lfsr);
         check_outs("R6 periph_rst pattern", "R7 clk_en pattern");
         bus_read(a, d);
         chk(lfsr[13] ? "R3 pattern readback" : "R2 pattern readback",
             {32'h0, d}, {32'h0, lfsr[9] ? m_stop[int'(lfsr[5])] : m_rst[int'(lfsr[5])]});
         // R9: request fields present but req_valid low
         bus_write(word_addr(int'(lfsr[9]), int'(lfsr[5]), ~lfsr[13]), ~lfsr, 1'b0);
         check_outs("R9 periph_rst no valid", "R9 clk_en no valid");
      end
      check_words("R9 words after invalid writes");

      // every undecoded offset: reads zero, writes ignored
      for (int a = 0; a < 4096; a++) begin
         if (!is_decoded(12'(a))) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            bus_write(12'(a), lfsr, 1'b1);
            bus_read(12'(a), d);
            chk("R8 undecoded read", {32'h0, d}, 64'h0);
         end
         if (a % 1024 == 1023) begin
            check_words("R8 words unchanged");
            check_outs("R8 periph_rst unchanged", "R8 clk_en unchanged");
         end
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule